// File: doc/BRIEF.md
# Fault Input Conditioner with Sticky Status

This block takes four asynchronous external fault lines and turns them into clean, clock-aligned fault indications. Each line is brought into the module clock domain by a two-stage synchronizer. A per-line polarity bit then chooses whether a high or a low level means "fault". A per-line detect enable decides whether the line takes part in detection at all. A per-line interrupt enable decides whether the line may set a latched interrupt flag.

Two further internal indications are carried alongside the pin faults: an oscillator-failure flag and a discontinuous-conduction flag. These are already in the module clock domain. They appear in both status words, and the block gives them no path to any fault routing logic.

Software sees two views. The live status word shows the fault state of every source as it is now. The sticky status word records every enabled event since it was last read, including single-cycle pulses, and a read strobe clears it. One interrupt line summarises the sticky word.

Top module: `faultPinStatus`

## Requirements
- R1: While `rstN` is low, the sticky status word is cleared, `irqOut` is low and both synchronizer stages of every pin are cleared. With the detect enables low and both extra flags low, the live status word therefore reads all zeros.
- R2: A level change on a fault pin reaches the live status word two rising clock edges after it is set up at the pin.
- R3: Polarity bit 1 makes a high synchronized level a fault, and polarity bit 0 makes a low level a fault, separately for each pin.
- R4: A pin whose detect enable is low reads 0 in the live status word and never sets its sticky bit.
- R5: Both status words use bits 3..0 for pins 3..0, bit 4 for oscillator failure and bit 5 for discontinuous-conduction detect. Bits 4 and 5 of the live word follow their inputs in the same cycle.
- R6: On each rising edge, a sticky bit is set when its live status bit is 1 and, for pins, that pin's interrupt enable is 1. The two extra flags are always enabled.
- R7: A sticky bit stays set after its source goes away, so a fault lasting one cycle is held until it is read.
- R8: `statusRead` high at a rising edge clears every sticky bit that has no new event at that same edge.
- R9: An event at the same edge as a clearing read leaves that sticky bit set.
- R10: `irqOut` is high exactly when at least one sticky status bit is set.
- R11: A pin whose interrupt enable is low still shows in the live status word but never sets its sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low reset |
| faultPin | input | 4 | Asynchronous fault lines, one bit per pin |
| pinPolarity | input | 4 | 1 = high is fault, 0 = low is fault |
| detectEn | input | 4 | Per-pin detection enable |
| intEn | input | 4 | Per-pin sticky/interrupt enable |
| oscFail | input | 1 | Oscillator failure flag (clock-domain signal) |
| dcmDetect | input | 1 | Discontinuous-conduction flag (clock-domain signal) |
| statusRead | input | 1 | One-cycle strobe: sticky word is being read |
| rawStatus | output | 6 | Live status word |
| intStatus | output | 6 | Sticky status word |
| irqOut | output | 1 | OR of the sticky status bits |

## Verification
The bench aims at the cases that decide whether short faults survive. A fault pulse of a single cycle must remain latched. A design that sampled only the live level would show it for one cycle and then drop it. A fault still present while the word is being read must stay set. A design that gave the clear priority would lose that event and leave `irqOut` low while the fault persists. Active-low pins, detect-disabled pins and interrupt-disabled pins are each driven. Swapped polarity sense, a leak of a disabled pin into the sticky word, or a wrong synchronizer depth would each show up as a live or sticky bit one cycle early, one cycle late, or plain wrong against the bench's cycle model.

// File: rtl/faultpin_pkg.sv
package faultpin_pkg;
  localparam int FP_PINS   = 4;
  localparam int FP_AUX    = 2;
  localparam int FP_STAT_W = FP_PINS + FP_AUX;

  // Strobes from the sticky control to the sticky register.
  typedef struct packed {
    logic [FP_STAT_W-1:0] setMask;
    logic                 clearAll;
  } fpStrobe_t;
endpackage

// File: rtl/fpCondDp.sv
module fpCondDp
  import faultpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FP_PINS-1:0]   faultPin,
  input  logic [FP_PINS-1:0]   pinPolarity,
  input  logic [FP_PINS-1:0]   detectEn,
  input  logic [FP_AUX-1:0]    auxIn,
  output logic [FP_STAT_W-1:0] rawStatus
);
  logic [FP_PINS-1:0] syncLevel;

  genvar p;
  generate
    for (p = 0; p < FP_PINS; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], faultPin[p]};
      end
      assign syncLevel[p] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic [FP_PINS-1:0] activeLevel;
  always_comb begin
    activeLevel = ~(syncLevel ^ pinPolarity);
    rawStatus   = {auxIn, activeLevel & detectEn};
  end
endmodule

// File: rtl/fpIntCtrl.sv
module fpIntCtrl
  import faultpin_pkg::*;
(
  input  logic [FP_STAT_W-1:0] rawStatus,
  input  logic [FP_PINS-1:0]   intEn,
  input  logic                 statusRead,
  output fpStrobe_t            strobe
);
  logic [FP_STAT_W-1:0] enMask;
  always_comb begin
    enMask          = {{FP_AUX{1'b1}}, intEn};
    strobe.setMask  = rawStatus & enMask;
    strobe.clearAll = statusRead;
  end
endmodule

// File: rtl/fpIntReg.sv
module fpIntReg
  import faultpin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  fpStrobe_t            strobe,
  output logic [FP_STAT_W-1:0] intStatus,
  output logic                 irqOut
);
  logic [FP_STAT_W-1:0] stickyNext;

  always_comb begin
    if (strobe.clearAll) stickyNext = strobe.setMask;
    else                 stickyNext = intStatus | strobe.setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStatus <= '0;
    else       intStatus <= stickyNext;
  end

  assign irqOut = |intStatus;

  // R9 / R7: every event strobe lands in the sticky word, read or not
  p_event_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMask != '0) |=> ((intStatus & $past(strobe.setMask)) == $past(strobe.setMask)));

  // R8: a clearing read leaves only the bits that had a new event
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> ((intStatus & ~$past(strobe.setMask)) == '0));

  // R6: no sticky bit rises without an event strobe
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((intStatus & ~$past(intStatus) & ~$past(strobe.setMask)) == '0));

  // R7: without a read, set bits never drop
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearAll |=> ((intStatus & $past(intStatus)) == $past(intStatus)));
endmodule

// File: rtl/faultPinStatus.sv
module faultPinStatus
  import faultpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FP_PINS-1:0]   faultPin,
  input  logic [FP_PINS-1:0]   pinPolarity,
  input  logic [FP_PINS-1:0]   detectEn,
  input  logic [FP_PINS-1:0]   intEn,
  input  logic                 oscFail,
  input  logic                 dcmDetect,
  input  logic                 statusRead,
  output logic [FP_STAT_W-1:0] rawStatus,
  output logic [FP_STAT_W-1:0] intStatus,
  output logic                 irqOut
);
  fpStrobe_t strobe;

  fpCondDp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .faultPin(faultPin), .pinPolarity(pinPolarity),
    .detectEn(detectEn), .auxIn({dcmDetect, oscFail}), .rawStatus(rawStatus)
  );

  fpIntCtrl u_ctrl (
    .rawStatus(rawStatus), .intEn(intEn), .statusRead(statusRead), .strobe(strobe)
  );

  fpIntReg u_reg (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intStatus(intStatus), .irqOut(irqOut)
  );

  // R10: the interrupt only drops after a read
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(statusRead));
endmodule

// File: tb/sim_faultPinStatus.sv
module sim_faultPinStatus;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] faultPin = '0, pinPolarity = '0, detectEn = '0, intEn = '0;
  logic oscFail = 1'b0, dcmDetect = 1'b0, statusRead = 1'b0;
  logic [5:0] rawStatus, intStatus;
  logic irqOut;

  always #10 clk = ~clk;

  faultPinStatus u0 (
    .clk(clk), .rstN(rstN), .faultPin(faultPin), .pinPolarity(pinPolarity),
    .detectEn(detectEn), .intEn(intEn), .oscFail(oscFail), .dcmDetect(dcmDetect),
    .statusRead(statusRead), .rawStatus(rawStatus), .intStatus(intStatus), .irqOut(irqOut)
  );

  typedef struct {
    logic [5:0] raw;
    logic [5:0] ist;
    logic       irq;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  logic [3:0] mS1 = '0, mS2 = '0;
  logic [5:0] mSticky = '0;

  task automatic check(input logic [5:0] aRaw, aIst, input logic aIrq, input expItem_t e);
    total++;
    if (aRaw !== e.raw || aIst !== e.ist || aIrq !== e.irq) begin
      bad++;
      $display("FAIL %s: raw=%b ist=%b irq=%b expected raw=%b ist=%b irq=%b",
               e.tag, aRaw, aIst, aIrq, e.raw, e.ist, e.irq);
    end
  endtask

  task automatic step(input logic [3:0] pins, pol, det, ie,
                      input logic osc, dcm, rd, input string tag);
    logic [5:0] rawBefore, ev;
    expItem_t it;
    @(negedge clk);
    faultPin = pins; pinPolarity = pol; detectEn = det; intEn = ie;
    oscFail = osc; dcmDetect = dcm; statusRead = rd;
    rawBefore = {dcm, osc, det & ~(mS2 ^ pol)};
    ev = rawBefore & {2'b11, ie};
    mSticky = rd ? ev : (mSticky | ev);
    mS2 = mS1;
    mS1 = pins;
    it.raw = {dcm, osc, det & ~(mS2 ^ pol)};
    it.ist = mSticky;
    it.irq = |mSticky;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: sample mid high phase, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(rawStatus, intStatus, irqOut, e);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    // R1: reset state
    r.raw = '0; r.ist = '0; r.irq = 1'b0; r.tag = "R1 reset";
    check(rawStatus, intStatus, irqOut, r);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R2: idle, active-high everywhere
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R1 idle");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R1 idle");
    // R2 / R7: single-cycle pulse on pin 0
    step(4'h1, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R2 pulse in");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R2 sync stage");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R2 raw shows pulse");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R7 pulse latched");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R10 irq held");
    // R8: read clears
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 1, "R8 read clears");
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R10 irq low");
    // R3: pin 3 active low, driven high -> no fault
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 high on active-low");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 high on active-low");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 no fault");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 1, "R8 clear");
    step(4'h0, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 drop");
    step(4'h0, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 sync");
    step(4'h0, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R3 low is fault");
    // R9: read while pin 3 still faulted
    step(4'h0, 4'h7, 4'hF, 4'hF, 0, 0, 1, "R9 event with read");
    step(4'h0, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R9 still set");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 1, "R9 read again");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 1, "R8 read");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 1, "R8 cleared");
    step(4'h8, 4'h7, 4'hF, 4'hF, 0, 0, 0, "R10 irq low");
    // R4: detect disabled
    step(4'hF, 4'hF, 4'h0, 4'hF, 0, 0, 0, "R4 det off");
    step(4'hF, 4'hF, 4'h0, 4'hF, 0, 0, 0, "R4 det off");
    step(4'hF, 4'hF, 4'h0, 4'hF, 0, 0, 0, "R4 raw zero");
    step(4'hF, 4'hF, 4'h0, 4'hF, 0, 0, 0, "R4 sticky zero");
    // R11: interrupt disabled but detected
    step(4'h2, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R11 ie off");
    step(4'h2, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R11 raw shows");
    step(4'h2, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R11 no sticky");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R11 no sticky");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R11 idle");
    // R5 / R6: extra flags, live and always enabled
    step(4'h0, 4'hF, 4'hF, 4'h0, 1, 0, 0, "R5 osc live");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 1, 0, "R6 osc latched, dcm live");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R5 both latched");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 0, 1, "R8 read clears extras");
    step(4'h0, 4'hF, 4'hF, 4'h0, 0, 0, 0, "R10 irq low");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      v = $urandom;
      step(v[3:0], v[7:4], v[11:8] | 4'h5, v[15:12], v[16] & v[17], v[18] & v[19],
           v[20] & v[21] & v[22], "R6 mixed");
    end
    step(4'h0, 4'hF, 4'hF, 4'hF, 0, 0, 0, "R6 drain");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule